// File: doc/BRIEF.md
# Three-Lane Clustered Decode Steering and Ordered Merge

This block sits between a branch-prediction front end and a rename stage. Each incoming descriptor names a fetch block by its first instruction address, its length in instructions, and whether the block closes with a taken branch. A block longer than one lane queue is cut at synthetic seams into chunks of at most the queue depth. Chunks are handed out to the decode lanes in strict rotation, so one long block is worked on by several lanes at once, each lane taking the next unassigned piece.

Each lane turns its chunk into micro-op tokens, one per instruction, each tagged with its address. A lane produces at most a fixed number of tokens per cycle into its own queue. It pauses, without losing anything, when the queue lacks room for the next group. A merge stage reads the queues back in program order. It finishes the chunk at the head of one lane before moving on to the next lane, and it may run across several chunk seams within one output beat, up to the beat width. A flush empties every queue, discards the held descriptor and any chunk in flight, and restarts the rotation at the first lane.

Top module: `clus_dec_steer`

## Requirements
- R1: After reset, `desc_ready` is 1 and `out_valid` is 0.
- R2: Every accepted block of length L at address A yields exactly L micro-ops, with addresses A + 4*i for i = 0..L-1 (default step 4). They leave in program order across all blocks.
- R3: `out_seam` is 1 exactly on the micro-op at in-block offset 31, 63, 95, ... and on the block's final micro-op. It is 0 on all others, so no chunk exceeds 32 instructions.
- R4: `out_brend` is 1 only on the final micro-op of a block that was accepted with `desc_taken` = 1.
- R5: Up to three chunks decode concurrently. With the output held off, three back-to-back 2-instruction blocks are all available in one 6-micro-op beat within 12 cycles.
- R6: One beat may span chunk seams and lanes, but `out_count` never exceeds 8. With output held, four 3-instruction blocks drain as a beat of 8 followed by a beat of 4.
- R7: A lane produces at most 3 micro-ops per cycle. A lone 9-instruction block, with the output always ready, drains in beats of exactly 3.
- R8: When the queues are full, decoding stalls and `desc_ready` drops while a long descriptor is pending. No micro-op is lost or duplicated when draining resumes.
- R9: In the cycle after a one-cycle `flush`, `out_valid` is 0 and `desc_ready` is 1. No micro-op of a block accepted before the flush appears afterwards.
- R10: `out_count` is between 0 and 8. Outside a flush, `out_valid` is 1 exactly when `out_count` is nonzero. Slots at index `out_count` and above carry no micro-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Misprediction flush: clears queues, held work and rotation |
| desc_valid | input | 1 | Fetch-block descriptor offered |
| desc_ready | output | 1 | Descriptor taken on this cycle's edge when valid |
| desc_addr | input | AW (32) | Address of the block's first instruction |
| desc_len | input | LEN_W (8) | Block length in instructions, 1 or more |
| desc_taken | input | 1 | Block ends with a taken branch |
| out_valid | output | 1 | A beat of micro-ops is offered |
| out_ready | input | 1 | Consumer takes the offered beat |
| out_count | output | 4 | Number of valid slots in the beat, 0 to 8 |
| out_addr | output | OUT_MAX*AW (256) | Slot k address at bits k*AW +: AW |
| out_seam | output | OUT_MAX (8) | Slot k is the last micro-op of its chunk |
| out_brend | output | OUT_MAX (8) | Slot k ends a block with a taken branch |

## Verification
The bench builds the block with its defaults: three lanes, 32-entry queues, 3 micro-ops per lane per cycle, 8-slot beats, 8-bit length and a 4-byte address step. An 8-bit length reaches blocks of up to 255 instructions. That covers splits into as many as eight chunks, so one block wraps the three-lane rotation more than twice, and it also makes it possible to fill all 96 queue entries behind a single descriptor. The small per-lane rate against the 8-wide beat brings within reach both the case where the merge is starved by one lane and the case where one beat crosses two or three lane seams.

// File: rtl/cds_pkg.sv
package cds_pkg;

   // per-token side flags carried beside the address
   typedef struct packed {
      logic seam;   // last token of its chunk
      logic brend;  // last token of a block that ends taken
   } tok_flg_t;

endpackage

// File: rtl/cds_split.sv
module cds_split #(
   parameter int AW        = 32,
   parameter int LEN_W     = 8,
   parameter int NLANES    = 3,
   parameter int QDEPTH    = 32,
   parameter int ADDR_STEP = 4,
   localparam int CL_W     = $clog2(QDEPTH + 1),
   localparam int LW       = (NLANES > 1) ? $clog2(NLANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              desc_valid,
   output logic              desc_ready,
   input  logic [AW-1:0]     desc_addr,
   input  logic [LEN_W-1:0]  desc_len,
   input  logic              desc_taken,
   input  logic [NLANES-1:0] lane_idle,
   output logic [NLANES-1:0] give,
   output logic [AW-1:0]     c_addr,
   output logic [CL_W-1:0]   c_len,
   output logic              c_brend
);

   logic             hold_v;
   logic [AW-1:0]    hold_addr;
   logic [LEN_W-1:0] hold_rem;
   logic             hold_tk;
   logic [LW-1:0]    rot;
   logic             final_c;
   logic             fire;

   assign final_c    = hold_rem <= LEN_W'(QDEPTH);
   assign c_len      = final_c ? CL_W'(hold_rem) : CL_W'(QDEPTH);
   assign c_addr     = hold_addr;
   assign c_brend    = final_c && hold_tk;
   assign fire       = hold_v && lane_idle[rot] && !flush;
   assign desc_ready = !flush && (!hold_v || (fire && final_c));

   always_comb begin
      give = '0;
      if (fire) give[rot] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         hold_v    <= 1'b0;
         hold_addr <= '0;
         hold_rem  <= '0;
         hold_tk   <= 1'b0;
         rot       <= '0;
      end else begin
         if (desc_valid && desc_ready) begin
            hold_v    <= 1'b1;
            hold_addr <= desc_addr;
            hold_rem  <= desc_len;
            hold_tk   <= desc_taken;
         end else if (fire) begin
            hold_addr <= hold_addr + AW'(c_len) * AW'(ADDR_STEP);
            hold_rem  <= hold_rem - LEN_W'(c_len);
            if (final_c) hold_v <= 1'b0;
         end
         if (fire) rot <= (rot == LW'(NLANES - 1)) ? '0 : rot + 1'b1;
      end
   end

   // R2
   desc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && desc_ready) |-> (desc_len != '0));

endmodule

// File: rtl/cds_lane.sv
module cds_lane
   import cds_pkg::*;
#(
   parameter int AW        = 32,
   parameter int QDEPTH    = 32,
   parameter int DEC_W     = 3,
   parameter int OUT_MAX   = 8,
   parameter int ADDR_STEP = 4,
   localparam int CL_W     = $clog2(QDEPTH + 1),
   localparam int OW       = $clog2(QDEPTH + 1),
   localparam int QW       = $clog2(QDEPTH),
   localparam int PW       = $clog2(OUT_MAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic            take,
   input  logic [AW-1:0]   c_addr,
   input  logic [CL_W-1:0] c_len,
   input  logic            c_brend,
   input  logic [PW-1:0]   pop_n,
   output logic            idle,
   output logic [OW-1:0]   occ,
   output logic [AW-1:0]   win_addr [OUT_MAX],
   output tok_flg_t        win_flg  [OUT_MAX]
);

   logic            busy;
   logic [AW-1:0]   d_addr;
   logic [CL_W-1:0] d_rem;
   logic            d_brend;
   logic [QW-1:0]   wr_ptr, rd_ptr;
   logic [CL_W-1:0] n;
   logic            wr_go;
   logic            last_grp;
   logic [AW-1:0]   mem_addr [QDEPTH];
   tok_flg_t        mem_flg  [QDEPTH];

   assign n        = (d_rem > CL_W'(DEC_W)) ? CL_W'(DEC_W) : d_rem;
   assign last_grp = (d_rem == n);
   assign wr_go    = busy && !flush && ((QDEPTH - int'(occ)) >= int'(n));
   assign idle     = !busy;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         busy    <= 1'b0;
         d_addr  <= '0;
         d_rem   <= '0;
         d_brend <= 1'b0;
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         occ     <= '0;
      end else begin
         if (take) begin
            busy    <= 1'b1;
            d_addr  <= c_addr;
            d_rem   <= c_len;
            d_brend <= c_brend;
         end else if (wr_go) begin
            d_addr <= d_addr + AW'(n) * AW'(ADDR_STEP);
            d_rem  <= d_rem - n;
            if (last_grp) busy <= 1'b0;
         end
         wr_ptr <= wr_ptr + (wr_go ? QW'(n) : '0);
         rd_ptr <= rd_ptr + QW'(pop_n);
         occ    <= occ + (wr_go ? OW'(n) : '0) - OW'(pop_n);
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEC_W; i++) begin
         if (wr_go && (i < int'(n))) begin
            mem_addr[wr_ptr + QW'(i)]      <= d_addr + AW'(i * ADDR_STEP);
            mem_flg[wr_ptr + QW'(i)].seam  <= last_grp && (i == int'(n) - 1);
            mem_flg[wr_ptr + QW'(i)].brend <= last_grp && (i == int'(n) - 1) && d_brend;
         end
      end
   end

   always_comb begin
      for (int k = 0; k < OUT_MAX; k++) begin
         win_addr[k] = mem_addr[rd_ptr + QW'(k)];
         win_flg[k]  = mem_flg[rd_ptr + QW'(k)];
      end
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= QDEPTH);

   // R2
   pop_le_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      OW'(pop_n) <= occ);

   // R3
   chunk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (!busy && c_len != '0 && int'(c_len) <= QDEPTH));

endmodule

// File: rtl/cds_merge.sv
module cds_merge
   import cds_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NLANES  = 3,
   parameter int OUT_MAX = 8,
   parameter int OW      = 6,
   parameter bit CROSS   = 1'b1,
   localparam int PW     = $clog2(OUT_MAX + 1),
   localparam int LW     = (NLANES > 1) ? $clog2(NLANES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          out_ready,
   input  logic [OW-1:0] occ      [NLANES],
   input  logic [AW-1:0] win_addr [NLANES][OUT_MAX],
   input  tok_flg_t      win_flg  [NLANES][OUT_MAX],
   output logic [PW-1:0] pop_n    [NLANES],
   output logic          out_valid,
   output logic [PW-1:0] out_count,
   output logic [AW-1:0] out_addr [OUT_MAX],
   output tok_flg_t      out_flg  [OUT_MAX]
);

   logic [LW-1:0] cur_q, cur_d, l;
   logic [PW-1:0] tk [NLANES];
   logic          stop;
   logic          fire;

   always_comb begin
      l         = cur_q;
      stop      = 1'b0;
      out_count = '0;
      for (int j = 0; j < NLANES; j++) tk[j] = '0;
      for (int k = 0; k < OUT_MAX; k++) begin
         out_addr[k] = '0;
         out_flg[k]  = '0;
         if (!stop) begin
            if (OW'(tk[l]) < occ[l]) begin
               out_addr[k] = win_addr[l][tk[l]];
               out_flg[k]  = win_flg[l][tk[l]];
               tk[l]       = tk[l] + 1'b1;
               out_count   = out_count + 1'b1;
               if (win_flg[l][tk[l] - 1'b1].seam) begin
                  l = (l == LW'(NLANES - 1)) ? '0 : l + 1'b1;
                  if (!CROSS) stop = 1'b1;
               end
            end else begin
               stop = 1'b1;
            end
         end
      end
      cur_d = l;
   end

   assign out_valid = (out_count != '0) && !flush;
   assign fire      = out_valid && out_ready;

   always_comb begin
      for (int j = 0; j < NLANES; j++) pop_n[j] = fire ? tk[j] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) cur_q <= '0;
      else if (fire)       cur_q <= cur_d;
   end

   // R6
   beat_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(out_count) <= OUT_MAX);

endmodule

// File: rtl/clus_dec_steer.sv
module clus_dec_steer
   import cds_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LEN_W     = 8,
   parameter int NLANES    = 3,
   parameter int QDEPTH    = 32,
   parameter int DEC_W     = 3,
   parameter int OUT_MAX   = 8,
   parameter int ADDR_STEP = 4,
   parameter bit CROSS     = 1'b1,
   localparam int CL_W     = $clog2(QDEPTH + 1),
   localparam int OW       = $clog2(QDEPTH + 1),
   localparam int PW       = $clog2(OUT_MAX + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic                  desc_valid,
   output logic                  desc_ready,
   input  logic [AW-1:0]         desc_addr,
   input  logic [LEN_W-1:0]      desc_len,
   input  logic                  desc_taken,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [PW-1:0]         out_count,
   output logic [OUT_MAX*AW-1:0] out_addr,
   output logic [OUT_MAX-1:0]    out_seam,
   output logic [OUT_MAX-1:0]    out_brend
);

   if (NLANES < 2)                      begin : g_bad_lanes $error("NLANES must be at least 2"); end
   if ((1 << $clog2(QDEPTH)) != QDEPTH) begin : g_bad_depth $error("QDEPTH must be a power of two"); end
   if (DEC_W < 1 || DEC_W > QDEPTH)     begin : g_bad_dec   $error("DEC_W out of range"); end
   if (OUT_MAX < 1 || OUT_MAX > QDEPTH) begin : g_bad_out   $error("OUT_MAX out of range"); end
   if (LEN_W < CL_W)                    begin : g_bad_len   $error("LEN_W too narrow for one chunk"); end

   logic [NLANES-1:0] lane_idle, give;
   logic [AW-1:0]     c_addr;
   logic [CL_W-1:0]   c_len;
   logic              c_brend;
   logic [OW-1:0]     occ      [NLANES];
   logic [AW-1:0]     win_addr [NLANES][OUT_MAX];
   tok_flg_t          win_flg  [NLANES][OUT_MAX];
   logic [PW-1:0]     pop_n    [NLANES];
   logic [AW-1:0]     m_addr   [OUT_MAX];
   tok_flg_t          m_flg    [OUT_MAX];

   cds_split #(.AW(AW), .LEN_W(LEN_W), .NLANES(NLANES), .QDEPTH(QDEPTH),
               .ADDR_STEP(ADDR_STEP)) split_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
      .desc_len(desc_len), .desc_taken(desc_taken),
      .lane_idle(lane_idle), .give(give),
      .c_addr(c_addr), .c_len(c_len), .c_brend(c_brend)
   );

   for (genvar g = 0; g < NLANES; g++) begin : g_lane
      cds_lane #(.AW(AW), .QDEPTH(QDEPTH), .DEC_W(DEC_W), .OUT_MAX(OUT_MAX),
                 .ADDR_STEP(ADDR_STEP)) lane_i (
         .clk(clk), .rst_n(rst_n), .flush(flush), .take(give[g]),
         .c_addr(c_addr), .c_len(c_len), .c_brend(c_brend),
         .pop_n(pop_n[g]), .idle(lane_idle[g]), .occ(occ[g]),
         .win_addr(win_addr[g]), .win_flg(win_flg[g])
      );
   end

   cds_merge #(.AW(AW), .NLANES(NLANES), .OUT_MAX(OUT_MAX), .OW(OW),
               .CROSS(CROSS)) merge_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .out_ready(out_ready),
      .occ(occ), .win_addr(win_addr), .win_flg(win_flg), .pop_n(pop_n),
      .out_valid(out_valid), .out_count(out_count),
      .out_addr(m_addr), .out_flg(m_flg)
   );

   for (genvar k = 0; k < OUT_MAX; k++) begin : g_pack
      assign out_addr[k*AW +: AW] = m_addr[k];
      assign out_seam[k]          = m_flg[k].seam;
      assign out_brend[k]         = m_flg[k].brend;
   end

   // R9
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush) && !flush) |-> (!out_valid && desc_ready));

   // R10
   valid_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |-> (out_valid == (out_count != '0)));

endmodule

// File: tb/clus_dec_steer_tb_top.sv
module clus_dec_steer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 32;
   localparam int OMAX = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           flush = 1'b0;
   logic           desc_valid = 1'b0;
   logic           desc_ready;
   logic [AW-1:0]  desc_addr = '0;
   logic [7:0]     desc_len = 8'd1;
   logic           desc_taken = 1'b0;
   logic           out_valid;
   logic           out_ready = 1'b0;
   logic [3:0]     out_count;
   logic [OMAX*AW-1:0] out_addr;
   logic [OMAX-1:0] out_seam, out_brend;

   int checks = 0;
   int errors = 0;
   int last_beat = 0;
   bit accepted = 0;
   bit watch3 = 0;
   int not3 = 0;
   int cyc = 0;

   logic [AW-1:0] ex_addr [$];
   bit            ex_seam [$];
   bit            ex_br   [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   clus_dec_steer dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
      .desc_len(desc_len), .desc_taken(desc_taken),
      .out_valid(out_valid), .out_ready(out_ready), .out_count(out_count),
      .out_addr(out_addr), .out_seam(out_seam), .out_brend(out_brend)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push_block(input logic [AW-1:0] a, input int len, input bit tk);
      for (int i = 0; i < len; i++) begin
         ex_addr.push_back(a + AW'(4 * i));
         ex_seam.push_back(((i % 32) == 31) || (i == len - 1));
         ex_br.push_back(tk && (i == len - 1));
      end
   endtask

   task automatic tick();
      #1;
      if (desc_valid && desc_ready) begin
         push_block(desc_addr, int'(desc_len), desc_taken);
         accepted = 1;
      end
      chk(out_count <= 4'd8, "R10 count range", out_count, 8);
      if (!flush)
         chk(out_valid == (out_count != 0), "R10 valid/count", out_valid, out_count != 0);
      last_beat = 0;
      if (out_valid && out_ready) begin
         last_beat = int'(out_count);
         if (watch3 && last_beat != 3) not3++;
         for (int k = 0; k < int'(out_count); k++) begin
            if (ex_addr.size() == 0) begin
               chk(0, "R2 extra micro-op", out_addr[k*AW +: AW], 0);
            end else begin
               chk(out_addr[k*AW +: AW] == ex_addr[0], "R2 address order",
                   out_addr[k*AW +: AW], ex_addr[0]);
               chk(out_seam[k] == ex_seam[0], "R3 seam flag", out_seam[k], ex_seam[0]);
               chk(out_brend[k] == ex_br[0], "R4 taken end flag", out_brend[k], ex_br[0]);
               void'(ex_addr.pop_front());
               void'(ex_seam.pop_front());
               void'(ex_br.pop_front());
            end
         end
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send(input logic [AW-1:0] a, input int len, input bit tk, input bit rnd);
      desc_valid = 1'b1; desc_addr = a; desc_len = 8'(len); desc_taken = tk;
      accepted = 0;
      while (!accepted) begin
         if (rnd) out_ready = ($urandom % 4) != 0;
         tick();
      end
      desc_valid = 1'b0;
   endtask

   task automatic drain();
      int guard = 0;
      out_ready = 1'b1;
      while ((ex_addr.size() != 0 || out_valid) && guard < 4000) begin
         tick();
         guard++;
      end
      repeat (4) tick();
      chk(ex_addr.size() == 0, "R2 all micro-ops delivered", ex_addr.size(), 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            chk(0, "watchdog", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1
      chk(desc_ready == 1'b1, "R1 reset desc_ready", desc_ready, 1);
      chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
      @(negedge clk);

      // R3 R4 directed splits
      send(32'h1000, 1, 1'b1, 1'b0);
      send(32'h2000, 32, 1'b0, 1'b0);
      send(32'h3000, 33, 1'b1, 1'b0);
      send(32'h4000, 255, 1'b1, 1'b0);
      drain();

      // R5: three 2-instruction blocks decoded in parallel
      out_ready = 1'b0;
      send(32'h5000, 2, 1'b0, 1'b0);
      send(32'h5100, 2, 1'b0, 1'b0);
      send(32'h5200, 2, 1'b1, 1'b0);
      repeat (12) tick();
      out_ready = 1'b1;
      tick();
      chk(last_beat == 6, "R5 parallel lanes beat", last_beat, 6);
      drain();

      // R6: beat crossing seams, capped at 8
      out_ready = 1'b0;
      send(32'h6000, 3, 1'b0, 1'b0);
      send(32'h6100, 3, 1'b0, 1'b0);
      send(32'h6200, 3, 1'b0, 1'b0);
      send(32'h6300, 3, 1'b1, 1'b0);
      repeat (20) tick();
      out_ready = 1'b1;
      tick();
      chk(last_beat == 8, "R6 first beat capped", last_beat, 8);
      tick();
      chk(last_beat == 4, "R6 second beat", last_beat, 4);
      drain();

      // R7: per-lane rate of 3
      out_ready = 1'b1;
      watch3 = 1; not3 = 0;
      send(32'h7000, 9, 1'b0, 1'b0);
      drain();
      watch3 = 0;
      chk(not3 == 0, "R7 beats of three", not3, 0);

      // R8: full queues stall input, nothing lost
      out_ready = 1'b0;
      send(32'h8000, 200, 1'b0, 1'b0);
      desc_valid = 1'b1; desc_addr = 32'h9000; desc_len = 8'd40; desc_taken = 1'b1;
      accepted = 0;
      repeat (80) tick();
      chk(accepted == 0, "R8 second descriptor held", accepted, 0);
      chk(desc_ready == 1'b0, "R8 desc_ready low when full", desc_ready, 0);
      out_ready = 1'b1;
      while (!accepted) tick();
      desc_valid = 1'b0;
      drain();

      // R9: flush drops all pending work
      out_ready = 1'b0;
      send(32'hA000, 50, 1'b1, 1'b0);
      send(32'hA100, 7, 1'b0, 1'b0);
      repeat (5) tick();
      flush = 1'b1;
      tick();
      flush = 1'b0;
      #1;
      chk(out_valid == 1'b0, "R9 out_valid after flush", out_valid, 0);
      chk(desc_ready == 1'b1, "R9 desc_ready after flush", desc_ready, 1);
      ex_addr.delete(); ex_seam.delete(); ex_br.delete();
      @(negedge clk);
      send(32'hB000, 5, 1'b1, 1'b0);
      send(32'hB100, 40, 1'b0, 1'b0);
      drain();

      // random mix
      for (int it = 0; it < 300; it++) begin
         int len;
         len = 1 + int'($urandom % 80);
         if (($urandom % 10) == 0) len = 1 + int'($urandom % 255);
         send(AW'($urandom) & 32'hFFFF_FFFC, len, 1'(($urandom % 2)), 1'b1);
         if (($urandom % 8) == 0) repeat (int'($urandom % 6)) begin
            out_ready = ($urandom % 2) != 0;
            tick();
         end
      end
      drain();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule